// File: doc/BRIEF.md
# Dual-Slope Ramp Interpolator Sequencer

This block sequences a capacitor-ramp time interpolator. External analog circuitry starts a fast charging current as soon as an asynchronous event arrives, provided the sequencer holds the fast path armed. The sequencer sees the event only after it has passed through a chain of flip-flops. At that report it drops the fast enable and raises the slow enable on the same clock edge. It also latches a free-running system time as the coarse timestamp of the event.

While the slow current discharges the capacitor, the block counts system clocks until a comparator says the ramp is back at its starting level. The count is the interval between the event and the report, stretched by the fixed ratio of the two currents. It is delivered unscaled, together with the coarse timestamp, and any division is left to downstream logic. If the comparator never fires, a bounded count ends the conversion with a timeout flag.

The result leaves on a valid/ready stream. `res_valid` stays high and the result fields stay frozen until `res_ready` is sampled high. A held-back result therefore extends the dead time. Events whose report falls inside the dead time do not start a conversion. Instead they add to a saturating miss counter. The comparator input is sampled on the system clock, so it must already be synchronous to `clk`.

Top module: `ramp_seq_ctrl`

## Requirements
- R1: After reset the block is armed: fast_en=1, slow_en=0, busy=0, res_valid=0, done=0 and miss_cnt=0.
- R2: A rising edge of event_in first sampled at clock edge k is reported at edge k+SYNC_STAGES, and busy is high after that edge. A level that stays high is reported only once.
- R3: At the report edge fast_en falls and slow_en rises together. fast_en and slow_en are never high at the same time.
- R4: res_coarse equals the number of rising clock edges since reset release that come before the report edge, modulo 2^TS_W.
- R5: res_stretch equals the number of cycles slow_en was high before cmp_zero was sampled high. cmp_zero is sampled only while slow_en is high.
- R6: If cmp_zero is still low after MAX_COUNT counted cycles, the result carries res_timeout=1 and res_stretch=MAX_COUNT. Otherwise res_timeout=0.
- R7: done is a one-cycle pulse on the edge where res_valid rises. While res_valid=1 and res_ready=0, res_valid and all result fields hold. The edge that samples res_ready=1 returns the block to the armed state.
- R8: busy is high from the report edge until the result is accepted, and fast_en is low whenever busy is high.
- R9: A report that arrives while busy starts no conversion and adds one to miss_cnt. miss_cnt saturates at 2^MISS_W-1 and never decreases outside reset.
- R10: Once a result is valid, both current enables are low until the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | 1 | Asynchronous event; the rising edge counts |
| cmp_zero | input | 1 | Comparator: ramp back at its starting level (synchronous) |
| fast_en | output | 1 | Fast charge current armed |
| slow_en | output | 1 | Slow discharge current on |
| busy | output | 1 | Dead time: report until result accepted |
| done | output | 1 | One-cycle pulse as a result becomes valid |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_coarse | output | TS_W | Coarse timestamp at the report edge |
| res_stretch | output | CNT_W | Stretched clock count |
| res_timeout | output | 1 | Conversion ended by the count limit |
| miss_cnt | output | MISS_W | Saturating count of events lost to dead time |

## Verification
The bench builds the block with three synchronizer stages, a stretch ratio of 8 (count limit 40), a 16-bit timestamp and a 3-bit miss counter. With these values the timeout path is reached within a few dozen cycles, and miss-counter saturation after only seven lost events. Three stages also show that the report latency follows the parameter rather than a fixed two. Stretch counts of zero, mid-range and the limit are all exercised, as is a result held back by res_ready low.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_SLOW  = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ramp_sync.sv
// Multi-stage synchronizer with a rising-edge report on its last stage.
module ramp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ramp_timebase.sv
// Free-running system-time counter.
module ramp_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_o <= '0;
    else        now_o <= now_o + 1'b1;
  end
endmodule

// File: rtl/ramp_miss_ctr.sv
// Saturating counter of events lost to dead time.
module ramp_miss_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_o <= '0;
    else if (hit_i && !(&cnt_o))   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ramp_seq_fsm.sv
// Conversion sequencer: armed -> slow discharge count -> result held.
module ramp_seq_fsm
  import ramp_seq_pkg::*;
#(
  parameter int TS_W      = 32,
  parameter int MAX_COUNT = 4000,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             report_i,
  input  logic             cmp_zero_i,
  input  logic [TS_W-1:0]  now_i,
  input  logic             res_ready_i,
  output logic             fast_en_o,
  output logic             slow_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             res_valid_o,
  output logic [TS_W-1:0]  res_coarse_o,
  output logic [CNT_W-1:0] res_stretch_o,
  output logic             res_timeout_o,
  output logic             miss_hit_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_ARMED;
      cnt_q         <= '0;
      res_coarse_o  <= '0;
      res_stretch_o <= '0;
      res_timeout_o <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_ARMED: begin
          if (report_i) begin
            st_q         <= ST_SLOW;
            res_coarse_o <= now_i;
            cnt_q        <= '0;
          end
        end
        ST_SLOW: begin
          if (cmp_zero_i) begin
            st_q          <= ST_DONE;
            res_stretch_o <= cnt_q;
            res_timeout_o <= 1'b0;
            done_o        <= 1'b1;
          end else if (cnt_q == LIMIT) begin
            st_q          <= ST_DONE;
            res_stretch_o <= cnt_q;
            res_timeout_o <= 1'b1;
            done_o        <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: begin
          if (res_ready_i) st_q <= ST_ARMED;
        end
        default: st_q <= ST_ARMED;
      endcase
    end
  end

  assign fast_en_o   = (st_q == ST_ARMED);
  assign slow_en_o   = (st_q == ST_SLOW);
  assign busy_o      = (st_q != ST_ARMED);
  assign res_valid_o = (st_q == ST_DONE);
  assign miss_hit_o  = report_i && (st_q != ST_ARMED);
endmodule

// File: rtl/ramp_seq_ctrl.sv
// Top: dual-slope ramp interpolator sequencer.
module ramp_seq_ctrl #(
  parameter int SYNC_STAGES   = 2,
  parameter int STRETCH_RATIO = 1000,
  parameter int MAX_COUNT     = STRETCH_RATIO * (SYNC_STAGES + 2),
  parameter int TS_W          = 32,
  parameter int MISS_W        = 8,
  localparam int CNT_W        = $clog2(MAX_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_in,
  input  logic              cmp_zero,
  output logic              fast_en,
  output logic              slow_en,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TS_W-1:0]   res_coarse,
  output logic [CNT_W-1:0]  res_stretch,
  output logic              res_timeout,
  output logic [MISS_W-1:0] miss_cnt
);
  logic            report;
  logic            miss_hit;
  logic [TS_W-1:0] now;

  ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(event_in), .rise_o(report)
  );

  ramp_timebase #(.W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .now_o(now)
  );

  ramp_seq_fsm #(.TS_W(TS_W), .MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .report_i(report), .cmp_zero_i(cmp_zero),
    .now_i(now), .res_ready_i(res_ready), .fast_en_o(fast_en),
    .slow_en_o(slow_en), .busy_o(busy), .done_o(done),
    .res_valid_o(res_valid), .res_coarse_o(res_coarse),
    .res_stretch_o(res_stretch), .res_timeout_o(res_timeout),
    .miss_hit_o(miss_hit)
  );

  ramp_miss_ctr #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .hit_i(miss_hit), .cnt_o(miss_cnt)
  );
endmodule

// File: rtl/ramp_seq_ctrl_chk.sv
module ramp_seq_ctrl_chk #(
  parameter int TS_W      = 32,
  parameter int CNT_W     = 12,
  parameter int MISS_W    = 8,
  parameter int MAX_COUNT = 4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fast_en,
  input logic              slow_en,
  input logic              busy,
  input logic              done,
  input logic              res_valid,
  input logic              res_ready,
  input logic [TS_W-1:0]   res_coarse,
  input logic [CNT_W-1:0]  res_stretch,
  input logic              res_timeout,
  input logic [MISS_W-1:0] miss_cnt
);
  AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fast_en && slow_en)); // R3
  AST_SLOW_SWAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(slow_en) |-> $fell(fast_en)); // R3
  AST_BUSY_NO_FAST: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !fast_en); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(res_valid)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_coarse) && $stable(res_stretch) && $stable(res_timeout))); // R7
  AST_STRETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> (res_stretch <= CNT_W'(MAX_COUNT))); // R6
  AST_TIMEOUT_FULL: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_timeout) |-> (res_stretch == CNT_W'(MAX_COUNT))); // R6
  AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> (!slow_en && !fast_en)); // R10
  AST_MISS_MONO: assert property (@(posedge clk) disable iff (!rst_n) miss_cnt >= $past(miss_cnt)); // R9
endmodule

bind ramp_seq_ctrl ramp_seq_ctrl_chk #(
  .TS_W(TS_W), .CNT_W(CNT_W), .MISS_W(MISS_W), .MAX_COUNT(MAX_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en),
  .busy(busy), .done(done), .res_valid(res_valid), .res_ready(res_ready),
  .res_coarse(res_coarse), .res_stretch(res_stretch),
  .res_timeout(res_timeout), .miss_cnt(miss_cnt)
);

// File: tb/ramp_seq_ctrl_test.sv
`timescale 1ns/1ps
module ramp_seq_ctrl_test;
  localparam int NS    = 3;
  localparam int RATIO = 8;
  localparam int MAXC  = RATIO * (NS + 2);
  localparam int TSW   = 16;
  localparam int MW    = 3;
  localparam int CW    = $clog2(MAXC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic event_in = 1'b0;
  logic res_ready = 1'b1;
  logic cmp_zero;
  logic fast_en, slow_en, busy, done, res_valid, res_timeout;
  logic [TSW-1:0] res_coarse;
  logic [CW-1:0]  res_stretch;
  logic [MW-1:0]  miss_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ramp_seq_ctrl #(.SYNC_STAGES(NS), .STRETCH_RATIO(RATIO), .TS_W(TSW), .MISS_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .cmp_zero(cmp_zero),
    .fast_en(fast_en), .slow_en(slow_en), .busy(busy), .done(done),
    .res_valid(res_valid), .res_ready(res_ready), .res_coarse(res_coarse),
    .res_stretch(res_stretch), .res_timeout(res_timeout), .miss_cnt(miss_cnt)
  );

  // Behavioural analog ramp: reaches start level k_target cycles into discharge.
  int k_target = 0;
  int elapsed = 0;
  always @(posedge clk) elapsed <= slow_en ? elapsed + 1 : 0;
  assign cmp_zero = slow_en && (elapsed >= k_target);

  // Reference model, advanced once per clock.
  bit hist[$];
  int m_st = 0, m_cnt = 0, m_coarse = 0, m_stretch = 0, m_miss = 0, m_time = 0;
  bit m_to = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i <= NS; i++) hist.push_back(1'b0);
      m_st = 0; m_cnt = 0; m_coarse = 0; m_stretch = 0; m_miss = 0;
      m_time = 0; m_to = 0; m_done = 0;
    end else begin
      automatic bit rep = hist[NS-1] && !hist[NS];
      automatic int pre = m_st;
      m_done = 0;
      case (m_st)
        0: if (rep) begin m_st = 1; m_coarse = m_time; m_cnt = 0; end
        1: if (cmp_zero) begin m_st = 2; m_stretch = m_cnt; m_to = 0; m_done = 1; end
           else if (m_cnt == MAXC) begin m_st = 2; m_stretch = m_cnt; m_to = 1; m_done = 1; end
           else m_cnt++;
        default: if (res_ready) m_st = 0;
      endcase
      if (rep && pre != 0 && m_miss < (1 << MW) - 1) m_miss++;
      m_time = (m_time + 1) % (1 << TSW);
      hist.push_front(event_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(fast_en == (m_st == 0), "R3 fast_en", fast_en, m_st == 0);
      check(slow_en == (m_st == 1), "R3 slow_en", slow_en, m_st == 1);
      check(busy == (m_st != 0), "R8 busy", busy, m_st != 0);
      check(res_valid == (m_st == 2), "R7 res_valid", res_valid, m_st == 2);
      check(done == m_done, "R7 done", done, m_done);
      check(miss_cnt == m_miss, "R9 miss_cnt", miss_cnt, m_miss);
      if (m_st == 2) begin
        check(res_coarse == m_coarse, "R4 res_coarse", res_coarse, m_coarse);
        check(res_stretch == m_stretch, "R5 res_stretch", res_stretch, m_stretch);
        check(res_timeout == m_to, "R6 res_timeout", res_timeout, m_to);
      end
    end
  end

  task automatic pulse_event();
    @(negedge clk) event_in = 1'b1;
    @(negedge clk) event_in = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 200 && !res_valid; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: armed reset state
    check(fast_en && !slow_en && !busy && !res_valid && !done && miss_cnt == 0,
          "R1 reset state", {fast_en, slow_en, busy, res_valid}, 4'b1000);

    // R2 latency and R5 mid-range count
    k_target = RATIO * NS + 5;
    @(negedge clk) event_in = 1'b1;      // sampled at the next posedge (edge k)
    repeat (NS) @(negedge clk);
    check(!busy, "R2 not yet reported", busy, 0);
    @(negedge clk);
    check(busy && slow_en && !fast_en, "R2 reported after SYNC_STAGES", busy, 1);
    event_in = 1'b0;
    wait_valid();
    check(res_stretch == k_target && !res_timeout, "R5 stretch count", res_stretch, k_target);
    @(negedge clk);
    check(!busy && fast_en, "R7 accept returns armed", busy, 0);

    // R5 zero-length discharge
    k_target = 0;
    pulse_event();
    wait_valid();
    check(res_stretch == 0, "R5 zero stretch", res_stretch, 0);
    @(negedge clk);

    // R6 timeout
    k_target = 1000;
    pulse_event();
    wait_valid();
    check(res_timeout && res_stretch == MAXC, "R6 timeout at limit", res_stretch, MAXC);
    @(negedge clk);

    // R7 back-pressure, R9 miss during held result, R10 enables off
    res_ready = 1'b0;
    k_target = 12;
    pulse_event();
    wait_valid();
    begin
      automatic int s0 = res_stretch;
      automatic int c0 = res_coarse;
      pulse_event();
      repeat (NS + 3) @(negedge clk);
      check(res_valid && res_stretch == s0 && res_coarse == c0, "R7 result held", res_stretch, s0);
      check(!slow_en && !fast_en, "R10 enables off while held", {fast_en, slow_en}, 0);
      check(miss_cnt == 1, "R9 miss counted", miss_cnt, 1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    check(!res_valid && !busy, "R7 accepted", res_valid, 0);

    // R2 held level reports once
    k_target = 3;
    @(negedge clk) event_in = 1'b1;
    repeat (30) @(negedge clk);
    check(!busy && miss_cnt == 1, "R2 held level once", miss_cnt, 1);
    event_in = 1'b0;
    repeat (NS + 2) @(negedge clk);

    // R9 saturation
    k_target = 1000;
    pulse_event();
    repeat (6) @(negedge clk);
    for (int i = 0; i < 10; i++) pulse_event();
    wait_valid();
    check(miss_cnt == (1 << MW) - 1, "R9 miss saturates", miss_cnt, (1 << MW) - 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule